// File: doc/BRIEF.md
# Thread-Tagged Shared Address Translation Buffer

This block is a small, fully associative translation cache used by two hardware threads together. Each slot holds a virtual page number, a physical page number, a global flag and the ID of the thread whose fill created it. A lookup presents a thread ID and a virtual page number. One clock later the block returns a hit flag and the physical page number. Entries owned by the other thread never match, even entries marked global.

A fill port writes new translations. The slot is chosen in this order: an existing entry with the same owner and page, then the lowest free slot, then a round-robin eviction pointer. Invalidation requests come from one thread at a time, in three kinds: an address-space-switch flush that keeps that thread's global entries, a paging-control flush that clears every entry of that thread, and a single-page invalidate. Each kind removes only entries whose owner tag equals the requester. When a flush and a fill arrive in the same cycle, the flush is applied first, so the new entry survives.

Top module: `txb_top`

## Requirements
- R1: While reset is high, and after it, every slot is invalid and rsp_valid, rsp_hit and rsp_ppn read 0. An entry filled before a reset misses afterwards.
- R2: A lookup sampled on a clock edge gives its result on outputs that are valid from that same edge. rsp_valid equals the lk_valid of the previous cycle. On a miss, rsp_ppn is 0.
- R3: A lookup hits only if a valid entry has a matching virtual page number and an owner tag equal to lk_thread. This holds for global entries too.
- R4: No invalidation request changes any entry owned by the thread that did not issue it.
- R5: inv_kind 2'b01 (address-space switch) removes every non-global entry of the requester and keeps the requester's global entries.
- R6: inv_kind 2'b10 (paging-control flush) removes every entry of the requester, global ones included.
- R7: inv_kind 2'b11 (single page) removes the requester's entry whose page equals inv_vpn, whether or not it is global. inv_kind 2'b00 does nothing.
- R8: A fill whose thread and page match an existing valid entry overwrites that entry. At most one entry ever matches a lookup.
- R9: A filled translation hits on lookups from the next cycle onward.
- R10: A fill with no matching entry goes to the lowest-numbered invalid slot. When every slot is valid, it evicts the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one on each such eviction.
- R11: When an invalidation and a fill arrive in the same cycle, the invalidation is applied first and the filled entry remains valid.
- R12: A lookup in the same cycle as a fill or invalidation sees the table as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_thread | input | TID_W | Thread issuing the lookup |
| lk_vpn | input | VPN_W | Virtual page to translate |
| rsp_valid | output | 1 | Registered: a lookup result is present |
| rsp_hit | output | 1 | Registered: the lookup hit |
| rsp_ppn | output | PPN_W | Registered physical page, 0 on miss |
| fill_valid | input | 1 | Write a translation |
| fill_thread | input | TID_W | Owner thread of the new entry |
| fill_vpn | input | VPN_W | Virtual page of the new entry |
| fill_ppn | input | PPN_W | Physical page of the new entry |
| fill_global | input | 1 | New entry is global |
| inv_valid | input | 1 | Invalidation request |
| inv_thread | input | TID_W | Requesting thread |
| inv_kind | input | 2 | 01 switch flush, 10 paging flush, 11 single page |
| inv_vpn | input | VPN_W | Page for the single-page kind |

## Verification
Some properties are checked on every cycle. After any invalidation, the other thread's valid bits stay stable. The requester keeps no entry that the request kind should have removed. A filled slot holds the new page and owner on the next cycle. Lookups never hit more than one slot. A fill never evicts a valid slot while a free one exists. Other behaviour can only be shown by the bench's scenarios: the exact physical page returned, global entries being invisible to the other thread, the round-robin eviction order once the buffer is full, and the same-cycle orderings of flush-with-fill and lookup-with-fill.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    INV_NOP    = 2'b00,
    INV_SWITCH = 2'b01,
    INV_PAGING = 2'b10,
    INV_ONE    = 2'b11
  } inv_kind_e;
endpackage

// File: rtl/txb_victim.sv
module txb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_valid,
  input  logic [ENTRIES-1:0] live_after_inv,
  input  logic [ENTRIES-1:0] same_key,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] free_idx, key_idx;
  logic             any_free, any_key;

  always_comb begin
    free_idx = '0;
    key_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live_after_inv[i]) free_idx = IDX_W'(i);
      if (same_key[i])        key_idx  = IDX_W'(i);
    end
    any_free = ~&live_after_inv;
    any_key  = |same_key;
    if (any_key)       slot = key_idx;
    else if (any_free) slot = free_idx;
    else               slot = rr_ptr;
  end

  always_ff @(posedge clk) begin
    if (rst)                                    rr_ptr <= '0;
    else if (fill_valid && !any_key && !any_free) rr_ptr <= rr_ptr + 1'b1;
  end

  // R10
  free_first_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && !any_key && any_free) |-> !live_after_inv[slot]);
endmodule

// File: rtl/txb_store.sv
module txb_store
  import txb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int TID_W   = 1,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fill_valid,
  input  logic [TID_W-1:0]   fill_thread,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic               fill_global,
  input  logic               inv_valid,
  input  logic [TID_W-1:0]   inv_thread,
  input  inv_kind_e          inv_kind,
  input  logic [VPN_W-1:0]   inv_vpn,
  output logic [ENTRIES-1:0] live,
  output logic [TID_W-1:0]   owner [ENTRIES],
  output logic [VPN_W-1:0]   vpage [ENTRIES],
  output logic [PPN_W-1:0]   ppage [ENTRIES]
);
  logic [ENTRIES-1:0] glob;
  logic [ENTRIES-1:0] drop, live_post, same_key;
  logic [ENTRIES-1:0] mine, mine_local, mine_page, fill_mask;
  logic [IDX_W-1:0]   slot;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      mine[i]       = live[i] && (owner[i] == inv_thread);
      mine_local[i] = mine[i] && !glob[i];
      mine_page[i]  = mine[i] && (vpage[i] == inv_vpn);
      drop[i] = 1'b0;
      if (inv_valid) begin
        case (inv_kind)
          INV_SWITCH: drop[i] = mine_local[i];
          INV_PAGING: drop[i] = mine[i];
          INV_ONE:    drop[i] = mine_page[i];
          default:    drop[i] = 1'b0;
        endcase
      end
    end
    live_post = live & ~drop;
    for (int i = 0; i < ENTRIES; i++)
      same_key[i] = live_post[i] && (owner[i] == fill_thread) && (vpage[i] == fill_vpn);
    fill_mask = '0;
    if (fill_valid) fill_mask[slot] = 1'b1;
  end

  txb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk            (clk),
    .rst            (rst),
    .fill_valid     (fill_valid),
    .live_after_inv (live_post),
    .same_key       (same_key),
    .slot           (slot)
  );

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else     live <= live_post | fill_mask;
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      owner[slot] <= fill_thread;
      vpage[slot] <= fill_vpn;
      ppage[slot] <= fill_ppn;
      glob[slot]  <= fill_global;
    end
  end

  logic [ENTRIES-1:0] other_mask;
  always_comb
    for (int i = 0; i < ENTRIES; i++) other_mask[i] = live[i] && (owner[i] != inv_thread);

  // R4
  other_thread_kept_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |=> ((live & $past(other_mask) & ~$past(fill_mask)) ==
                   ($past(other_mask) & ~$past(fill_mask))));
  // R5
  switch_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_kind == INV_SWITCH) |=>
      ((live & $past(mine_local) & ~$past(fill_mask)) == '0));
  // R6
  paging_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_kind == INV_PAGING) |=>
      ((live & $past(mine) & ~$past(fill_mask)) == '0));
  // R7
  one_page_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && inv_kind == INV_ONE) |=>
      ((live & $past(mine_page) & ~$past(fill_mask)) == '0));
  // R9
  fill_lands_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (live[$past(slot)] && vpage[$past(slot)] == $past(fill_vpn) &&
                    owner[$past(slot)] == $past(fill_thread)));
endmodule

// File: rtl/txb_lookup.sv
module txb_lookup #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int TID_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [TID_W-1:0]   lk_thread,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ENTRIES-1:0] live,
  input  logic [TID_W-1:0]   owner [ENTRIES],
  input  logic [VPN_W-1:0]   vpage [ENTRIES],
  input  logic [PPN_W-1:0]   ppage [ENTRIES],
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PPN_W-1:0]   rsp_ppn
);
  logic [ENTRIES-1:0] hit_vec;
  logic [PPN_W-1:0]   ppn_sel;

  always_comb begin
    ppn_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = live[i] && (owner[i] == lk_thread) && (vpage[i] == lk_vpn);
      ppn_sel    = ppn_sel | (hit_vec[i] ? ppage[i] : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|hit_vec);
      rsp_ppn   <= lk_valid ? ppn_sel : '0;
    end
  end

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $onehot0(hit_vec));
  // R2
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_ppn == '0));
endmodule

// File: rtl/txb_top.sv
module txb_top
  import txb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int THREADS = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [TID_W-1:0] lk_thread,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  input  logic             fill_valid,
  input  logic [TID_W-1:0] fill_thread,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_global,
  input  logic             inv_valid,
  input  logic [TID_W-1:0] inv_thread,
  input  logic [1:0]       inv_kind,
  input  logic [VPN_W-1:0] inv_vpn
);
  logic [ENTRIES-1:0] live;
  logic [TID_W-1:0]   owner [ENTRIES];
  logic [VPN_W-1:0]   vpage [ENTRIES];
  logic [PPN_W-1:0]   ppage [ENTRIES];

  txb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .TID_W(TID_W)) u_store (
    .clk (clk), .rst (rst),
    .fill_valid (fill_valid), .fill_thread (fill_thread), .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn), .fill_global (fill_global),
    .inv_valid (inv_valid), .inv_thread (inv_thread),
    .inv_kind (inv_kind_e'(inv_kind)), .inv_vpn (inv_vpn),
    .live (live), .owner (owner), .vpage (vpage), .ppage (ppage)
  );

  txb_lookup #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .TID_W(TID_W)) u_lookup (
    .clk (clk), .rst (rst),
    .lk_valid (lk_valid), .lk_thread (lk_thread), .lk_vpn (lk_vpn),
    .live (live), .owner (owner), .vpage (vpage), .ppage (ppage),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_ppn (rsp_ppn)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rsp_hit && live == '0));
endmodule

// File: tb/txb_top_test.sv
module txb_top_test;
  localparam int VPN_W = 20;
  localparam int PPN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 0, fill_valid = 0, fill_global = 0, inv_valid = 0;
  logic [0:0] lk_thread = 0, fill_thread = 0, inv_thread = 0;
  logic [VPN_W-1:0] lk_vpn = 0, fill_vpn = 0, inv_vpn = 0;
  logic [PPN_W-1:0] fill_ppn = 0;
  logic [1:0] inv_kind = 0;
  logic rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  txb_top uut (
    .clk (clk), .rst (rst),
    .lk_valid (lk_valid), .lk_thread (lk_thread), .lk_vpn (lk_vpn),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_ppn (rsp_ppn),
    .fill_valid (fill_valid), .fill_thread (fill_thread), .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn), .fill_global (fill_global),
    .inv_valid (inv_valid), .inv_thread (inv_thread), .inv_kind (inv_kind),
    .inv_vpn (inv_vpn)
  );

  typedef enum logic [2:0] {OP_FILL, OP_LOOK, OP_SW, OP_PG, OP_ONE} op_e;
  typedef struct packed {
    op_e              op;
    logic             thr;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             glob;
    logic             hit;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{OP_FILL, 1'b0, 20'h10, 16'h110, 1'b0, 1'b0},
    '{OP_FILL, 1'b1, 20'h10, 16'h210, 1'b0, 1'b0},
    '{OP_FILL, 1'b0, 20'h20, 16'h120, 1'b1, 1'b0},
    '{OP_FILL, 1'b1, 20'h20, 16'h220, 1'b1, 1'b0},
    '{OP_FILL, 1'b0, 20'h30, 16'h130, 1'b0, 1'b0},
    '{OP_LOOK, 1'b0, 20'h10, 16'h110, 1'b0, 1'b1},
    '{OP_LOOK, 1'b1, 20'h10, 16'h210, 1'b0, 1'b1},
    '{OP_LOOK, 1'b0, 20'h40, 16'h000, 1'b0, 1'b0},
    '{OP_SW,   1'b0, 20'h00, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b0, 20'h10, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b0, 20'h20, 16'h120, 1'b0, 1'b1},
    '{OP_LOOK, 1'b1, 20'h10, 16'h210, 1'b0, 1'b1},
    '{OP_ONE,  1'b1, 20'h20, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b1, 20'h20, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b0, 20'h20, 16'h120, 1'b0, 1'b1},
    '{OP_PG,   1'b0, 20'h00, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b0, 20'h20, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b0, 20'h30, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b1, 20'h10, 16'h210, 1'b0, 1'b1},
    '{OP_ONE,  1'b0, 20'h10, 16'h000, 1'b0, 1'b0},
    '{OP_LOOK, 1'b1, 20'h10, 16'h210, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    lk_valid = 0; fill_valid = 0; inv_valid = 0;
  endtask

  task automatic put_fill(input logic t, input logic [VPN_W-1:0] v,
                          input logic [PPN_W-1:0] p, input logic g);
    fill_valid = 1; fill_thread = t; fill_vpn = v; fill_ppn = p; fill_global = g;
  endtask

  task automatic put_inv(input logic t, input logic [1:0] k, input logic [VPN_W-1:0] v);
    inv_valid = 1; inv_thread = t; inv_kind = k; inv_vpn = v;
  endtask

  task automatic put_look(input logic t, input logic [VPN_W-1:0] v);
    lk_valid = 1; lk_thread = t; lk_vpn = v;
  endtask

  task automatic expect_rsp(input bit h, input logic [PPN_W-1:0] p, input string req);
    check(rsp_valid === 1'b1, req, {31'd0, rsp_valid}, 32'd1);
    check(rsp_hit === h, req, {31'd0, rsp_hit}, {31'd0, h});
    check(rsp_ppn === (h ? p : '0), req, {16'd0, rsp_ppn}, {16'd0, (h ? p : 16'd0)});
  endtask

  task automatic look(input logic t, input logic [VPN_W-1:0] v, input bit h,
                      input logic [PPN_W-1:0] p, input string req);
    put_look(t, v);
    tick();
    expect_rsp(h, p, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check(rsp_valid === 0 && rsp_hit === 0 && rsp_ppn === 0, "R1 reset outputs",
          {rsp_valid, rsp_hit, rsp_ppn}, 32'd0);
    rst = 0;
    @(negedge clk);
    // R2: no lookup means no response
    check(rsp_valid === 0, "R2 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // Table walk: R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      case (VEC[k].op)
        OP_FILL: begin put_fill(VEC[k].thr, VEC[k].vpn, VEC[k].ppn, VEC[k].glob); tick(); end
        OP_SW:   begin put_inv(VEC[k].thr, 2'b01, VEC[k].vpn); tick(); end
        OP_PG:   begin put_inv(VEC[k].thr, 2'b10, VEC[k].vpn); tick(); end
        OP_ONE:  begin put_inv(VEC[k].thr, 2'b11, VEC[k].vpn); tick(); end
        default: look(VEC[k].thr, VEC[k].vpn, VEC[k].hit, VEC[k].ppn,
                      $sformatf("R3/R4/R5/R6/R7 vector %0d", k));
      endcase
    end

    // R3: a global entry of thread 0 is not visible to thread 1
    put_fill(0, 20'h60, 16'h160, 1); tick();
    look(1, 20'h60, 0, 0, "R3 global cross-thread");
    look(0, 20'h60, 1, 16'h160, "R3 global own thread");

    // R12: same-cycle fill and lookup see the old table; R9: next cycle hits
    put_fill(1, 20'h70, 16'h270, 0); put_look(1, 20'h70); tick();
    expect_rsp(0, 0, "R12 lookup with fill");
    look(1, 20'h70, 1, 16'h270, "R9 fill visible");

    // R8: refill of the same key overwrites
    put_fill(1, 20'h70, 16'h999, 0); tick();
    look(1, 20'h70, 1, 16'h999, "R8 overwrite");

    // R11: flush and fill together, the flush goes first
    put_fill(0, 20'h50, 16'h150, 0); tick();
    put_inv(0, 2'b10, 0); put_fill(0, 20'h51, 16'h151, 0); tick();
    look(0, 20'h50, 0, 0, "R11 old entry flushed");
    look(0, 20'h51, 1, 16'h151, "R11 new entry kept");
    look(1, 20'h70, 1, 16'h999, "R4 other thread after flush");

    // R7: kind 00 has no effect
    put_inv(1, 2'b00, 20'h70); tick();
    look(1, 20'h70, 1, 16'h999, "R7 no-op kind");

    // R1: reset clears entries
    rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    look(1, 20'h70, 0, 0, "R1 entry gone after reset");

    // R10: fill all 16 slots, then evict in round-robin order
    for (int i = 0; i < 16; i++) begin
      put_fill(0, VPN_W'(i), PPN_W'(16'h300 + i), 0); tick();
    end
    look(0, 20'd15, 1, 16'h30f, "R10 full buffer");
    put_fill(0, 20'd100, 16'h400, 0); tick();
    put_fill(0, 20'd101, 16'h401, 0); tick();
    look(0, 20'd0, 0, 0, "R10 slot 0 evicted first");
    look(0, 20'd1, 0, 0, "R10 slot 1 evicted second");
    look(0, 20'd2, 1, 16'h302, "R10 slot 2 kept");
    look(0, 20'd100, 1, 16'h400, "R10 new entry");
    // R10: a freed slot is reused before the pointer
    put_inv(0, 2'b11, 20'd9); tick();
    put_fill(0, 20'd102, 16'h402, 0); tick();
    look(0, 20'd2, 1, 16'h302, "R10 free slot used first");
    look(0, 20'd102, 1, 16'h402, "R10 free slot fill");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule